// File: doc/BRIEF.md
# Serial Stuck-At Fault Grading Engine

This block grades a stored set of test vectors against a small combinational circuit that is built into the block. Every line of that circuit passes through a fault-injection multiplexer, so any single line can be held at 0 or at 1 while the rest of the circuit stays intact. Software, or a test sequencer, writes up to `VEC_DEPTH` two-bit vectors through a simple write port. It sets the number of vectors in use and pulses `start`. The engine then grades the set against the first `NUM_FAULTS` entries of the fault list.

A run has two phases. In the first, the engine applies every vector to the circuit with no fault present and records each response. In the second, it visits the faults in order of their index. For each fault it forces that one line, replays the vectors from the first, and compares each response with the recorded fault-free response. The first difference marks the fault as detected and ends that fault's replay at once. When the list is exhausted, `done` pulses for one cycle. A flag per fault and a count of detected faults stay on the outputs until the next start. Coverage is `det_count / NUM_FAULTS`, and the undetected faults are the clear bits of `det_flags`.

The controller is a five-state machine:
- IDLE waits for `start`.
- GOOD_RUN records the fault-free responses.
- FAULT_RUN replays vectors with one fault forced.
- NEXT_FAULT advances to the next fault.
- FINISH raises `done`.

Its transitions are:
- IDLE goes to GOOD_RUN on start, or to FINISH on start with an empty set.
- GOOD_RUN goes to FAULT_RUN after its last vector.
- FAULT_RUN goes to NEXT_FAULT on a mismatch or after its last vector.
- NEXT_FAULT goes back to FAULT_RUN, or to FINISH after the last fault.
- FINISH goes to IDLE.

Top module: `fsg_engine`

## Requirements
- R1: After reset, `busy`, `done`, `det_count` and `det_flags` are all zero.
- R2: A `start` sampled in IDLE makes `busy` high on the next cycle. A `start` sampled while `busy` is high has no effect, so the run length and the results are unchanged.
- R3: GOOD_RUN spends exactly one cycle per vector, in address order from 0 to `vec_count-1`. The responses it records are the fault-free reference for every later comparison.
- R4: Fault index f forces site `f>>1` to the value `f[0]`. The sites are numbered as follows: 0 is the stem of input p, 1 is the stem of input q, 2 is the branch p→G1, 3 is the branch q→G1, 4 is the stem of G1, 5 is the branch p→G2, 6 is the branch G1→G2, 7 is the branch G1→G3, 8 is the branch q→G3, 9 is G2, 10 is G3 and 11 is the output G4. Vector bit 1 is p and bit 0 is q.
- R5: Exactly one fault is forced during each fault replay. `det_flags[f]` is set if and only if some vector in the set gives a response that differs from the fault-free one under fault f.
- R6: A fault replay ends at the first differing vector. A fault whose first detecting vector has position k (counting from 1) costs k+1 cycles, and an undetected fault costs V+1 cycles. With V vectors, `done` is high in the cycle that follows the (1 + V + Σ cost)-th rising edge, counted from the edge that samples `start`.
- R7: `det_count` equals the number of set bits in `det_flags`. Both hold their values after `done` until the next accepted start, which clears them.
- R8: `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R9: When `vec_count` is 0, no fault is detected, `det_count` is 0, and `done` follows one cycle after start.
- R10: The circuit under grade is G1=NAND(p,q), G2=NAND(p,G1), G3=NAND(q,G1), out=G4=NAND(G2,G3). Its fault-free response is p XOR q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a grading run when the engine is idle |
| vec_count | input | CW | Number of vectors in use, from 0 to VEC_DEPTH; sampled at start |
| vec_we | input | 1 | Vector memory write strobe; write only while idle |
| vec_addr | input | AW | Vector memory write address |
| vec_wdata | input | 2 | Vector written; bit 1 is p and bit 0 is q |
| busy | output | 1 | High while recording responses or grading faults |
| done | output | 1 | One-cycle pulse at the end of a run |
| det_count | output | DCW | Number of detected faults |
| det_flags | output | NUM_FAULTS | One bit per fault index; a bit is set when that fault is detected |

## Verification
Every result is due at a cycle the bench can compute in advance. `busy` rises one edge after the edge that samples `start`. `done` rises after the edge number given in R6, which the bench works out from its own model of the circuit: it finds the first detecting vector for each fault. The bench counts rising edges from the start edge and samples the outputs at the falling edge. It compares that count with the expected latency, and then checks that `done` falls one cycle later. It reads the flags and the count only after `done` and again after several idle cycles. It covers every one- and two-vector set, the full four-vector set, a full-depth set, an empty set, and a run that receives an extra start while busy.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int NSITES = 12;
    localparam int SITE_W = 4;
    localparam int VEC_W  = 2;

    // site numbering: the fault index is site*2 + stuck value
    localparam int S_P      = 0;
    localparam int S_Q      = 1;
    localparam int S_P_G1   = 2;
    localparam int S_Q_G1   = 3;
    localparam int S_G1     = 4;
    localparam int S_P_G2   = 5;
    localparam int S_G1_G2  = 6;
    localparam int S_G1_G3  = 7;
    localparam int S_Q_G3   = 8;
    localparam int S_G2     = 9;
    localparam int S_G3     = 10;
    localparam int S_OUT    = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GOOD_RUN,
        ST_FAULT_RUN,
        ST_NEXT_FAULT,
        ST_FINISH
    } fsg_state_e;

endpackage

// File: rtl/fsg_netlist.sv
module fsg_netlist
    import fsg_pkg::*;
(
    input  logic [VEC_W-1:0]  vec,
    input  logic              fault_en,
    input  logic [SITE_W-1:0] fault_site,
    input  logic              fault_val,
    output logic              resp
);

    logic [NSITES-1:0] hit;

    // one select per site; at most one is active for a given site number
    genvar gi;
    generate
        for (gi = 0; gi < NSITES; gi++) begin : g_site
            assign hit[gi] = fault_en && (fault_site == SITE_W'(gi));
        end
    endgenerate

    logic p, q, p_g1, q_g1, g1, g1_raw;
    logic p_g2, g1_g2, g1_g3, q_g3;
    logic g2, g2_raw, g3, g3_raw, g4_raw;

    always_comb begin
        p      = hit[S_P]     ? fault_val : vec[1];
        q      = hit[S_Q]     ? fault_val : vec[0];
        p_g1   = hit[S_P_G1]  ? fault_val : p;
        q_g1   = hit[S_Q_G1]  ? fault_val : q;
        g1_raw = ~(p_g1 & q_g1);
        g1     = hit[S_G1]    ? fault_val : g1_raw;
        p_g2   = hit[S_P_G2]  ? fault_val : p;
        g1_g2  = hit[S_G1_G2] ? fault_val : g1;
        g1_g3  = hit[S_G1_G3] ? fault_val : g1;
        q_g3   = hit[S_Q_G3]  ? fault_val : q;
        g2_raw = ~(p_g2 & g1_g2);
        g2     = hit[S_G2]    ? fault_val : g2_raw;
        g3_raw = ~(q_g3 & g1_g3);
        g3     = hit[S_G3]    ? fault_val : g3_raw;
        g4_raw = ~(g2 & g3);
        resp   = hit[S_OUT]   ? fault_val : g4_raw;
    end

endmodule

// File: rtl/fsg_vecmem.sv
module fsg_vecmem
    import fsg_pkg::*;
#(
    parameter int VEC_DEPTH = 16,
    localparam int AW = (VEC_DEPTH > 1) ? $clog2(VEC_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [VEC_W-1:0] rd_vec,
    input  logic             ref_we,
    input  logic             ref_bit,
    output logic             ref_q
);

    logic [VEC_W-1:0] vmem [VEC_DEPTH];
    logic [VEC_DEPTH-1:0] ref_bank;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            vmem[wr_addr] <= wr_data;
        end
        if (ref_we) begin
            ref_bank[rd_addr] <= ref_bit;
        end
    end

    assign rd_vec = vmem[rd_addr];
    assign ref_q  = ref_bank[rd_addr];

endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
#(
    parameter int VEC_DEPTH  = 16,
    parameter int NUM_FAULTS = 24,
    localparam int AW  = (VEC_DEPTH > 1) ? $clog2(VEC_DEPTH) : 1,
    localparam int CW  = $clog2(VEC_DEPTH + 1),
    localparam int FW  = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1,
    localparam int DCW = $clog2(NUM_FAULTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CW-1:0]         vec_count,
    input  logic                  resp,
    input  logic                  ref_q,
    output logic [AW-1:0]         vidx,
    output logic                  fault_en,
    output logic [SITE_W-1:0]     fault_site,
    output logic                  fault_val,
    output logic                  ref_we,
    output logic                  busy,
    output logic                  done,
    output logic [DCW-1:0]        det_count,
    output logic [NUM_FAULTS-1:0] det_flags
);

    fsg_state_e state, state_nx;

    logic [CW-1:0] nvec_q;
    logic [FW-1:0] fidx;
    logic          last_vec;
    logic          last_fault;
    logic          mismatch;

    assign last_vec   = ((CW'(vidx) + CW'(1)) == nvec_q);
    assign last_fault = (fidx == FW'(NUM_FAULTS - 1));
    assign mismatch   = (resp != ref_q);
    assign fault_site = SITE_W'(fidx >> 1);
    assign fault_val  = fidx[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = (vec_count == '0) ? ST_FINISH : ST_GOOD_RUN;
                end
            end
            ST_GOOD_RUN: begin
                if (last_vec) state_nx = ST_FAULT_RUN;
            end
            ST_FAULT_RUN: begin
                if (mismatch || last_vec) state_nx = ST_NEXT_FAULT;
            end
            ST_NEXT_FAULT: begin
                state_nx = last_fault ? ST_FINISH : ST_FAULT_RUN;
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        fault_en = 1'b0;
        ref_we   = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_GOOD_RUN:   begin busy = 1'b1; ref_we = 1'b1; end
            ST_FAULT_RUN:  begin busy = 1'b1; fault_en = 1'b1; end
            ST_NEXT_FAULT: busy = 1'b1;
            ST_FINISH:     done = 1'b1;
            default:       ;
        endcase
    end

    // counters, flags and captured vector count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nvec_q    <= '0;
            vidx      <= '0;
            fidx      <= '0;
            det_count <= '0;
            det_flags <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        nvec_q    <= vec_count;
                        vidx      <= '0;
                        fidx      <= '0;
                        det_count <= '0;
                        det_flags <= '0;
                    end
                end
                ST_GOOD_RUN: begin
                    vidx <= last_vec ? '0 : vidx + AW'(1);
                end
                ST_FAULT_RUN: begin
                    if (mismatch) begin
                        det_flags[fidx] <= 1'b1;
                        det_count       <= det_count + DCW'(1);
                    end else if (!last_vec) begin
                        vidx <= vidx + AW'(1);
                    end
                end
                ST_NEXT_FAULT: begin
                    vidx <= '0;
                    if (!last_fault) fidx <= fidx + FW'(1);
                end
                default: ;
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    det_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (det_count == $past(det_count)) ||
                 (det_count == $past(det_count) + DCW'(1)));

    // R3
    vidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (CW'(vidx) < nvec_q));

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done) && (det_count >= $past(det_count)));

    // R5
    one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_en |-> busy && (fault_site < SITE_W'(NSITES)));

endmodule

// File: rtl/fsg_engine.sv
module fsg_engine
    import fsg_pkg::*;
#(
    parameter int VEC_DEPTH  = 16,
    parameter int NUM_FAULTS = 24,
    localparam int AW  = (VEC_DEPTH > 1) ? $clog2(VEC_DEPTH) : 1,
    localparam int CW  = $clog2(VEC_DEPTH + 1),
    localparam int DCW = $clog2(NUM_FAULTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CW-1:0]         vec_count,
    input  logic                  vec_we,
    input  logic [AW-1:0]         vec_addr,
    input  logic [1:0]            vec_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [DCW-1:0]        det_count,
    output logic [NUM_FAULTS-1:0] det_flags
);

    logic [AW-1:0]     vidx;
    logic [VEC_W-1:0]  cur_vec;
    logic              fault_en;
    logic [SITE_W-1:0] fault_site;
    logic              fault_val;
    logic              resp;
    logic              ref_we;
    logic              ref_q;

    fsg_vecmem #(.VEC_DEPTH(VEC_DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (vec_we),
        .wr_addr (vec_addr),
        .wr_data (vec_wdata),
        .rd_addr (vidx),
        .rd_vec  (cur_vec),
        .ref_we  (ref_we),
        .ref_bit (resp),
        .ref_q   (ref_q)
    );

    fsg_netlist u_cut (
        .vec        (cur_vec),
        .fault_en   (fault_en),
        .fault_site (fault_site),
        .fault_val  (fault_val),
        .resp       (resp)
    );

    fsg_ctrl #(.VEC_DEPTH(VEC_DEPTH), .NUM_FAULTS(NUM_FAULTS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vec_count  (vec_count),
        .resp       (resp),
        .ref_q      (ref_q),
        .vidx       (vidx),
        .fault_en   (fault_en),
        .fault_site (fault_site),
        .fault_val  (fault_val),
        .ref_we     (ref_we),
        .busy       (busy),
        .done       (done),
        .det_count  (det_count),
        .det_flags  (det_flags)
    );

    initial begin
        if (NUM_FAULTS > 2 * NSITES || NUM_FAULTS < 1) begin
            $error("NUM_FAULTS out of range");
        end
    end

endmodule

// File: tb/tb_fsg_engine.sv
`timescale 1ns/1ps
module tb_fsg_engine;

    localparam int VD  = 16;
    localparam int NF  = 24;
    localparam int CW  = 5;
    localparam int AW  = 4;
    localparam int DCW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] vec_count = '0;
    logic          vec_we = 1'b0;
    logic [AW-1:0] vec_addr = '0;
    logic [1:0]    vec_wdata = '0;
    logic          busy, done;
    logic [DCW-1:0] det_count;
    logic [NF-1:0]  det_flags;

    always #2 clk = ~clk;

    fsg_engine #(.VEC_DEPTH(VD), .NUM_FAULTS(NF)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_count(vec_count),
        .vec_we(vec_we), .vec_addr(vec_addr), .vec_wdata(vec_wdata),
        .busy(busy), .done(done), .det_count(det_count), .det_flags(det_flags)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [1:0] vset [VD];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference response of the specified circuit under one fault (R4, R10)
    function automatic bit model(input logic [1:0] v, input int fid, input bit en);
        int s;
        bit val, p, q, pg1, qg1, g1, pg2, g1g2, g1g3, qg3, g2, g3, y;
        s = en ? fid / 2 : -1;
        val = bit'(fid % 2);
        p    = (s == 0)  ? val : v[1];
        q    = (s == 1)  ? val : v[0];
        pg1  = (s == 2)  ? val : p;
        qg1  = (s == 3)  ? val : q;
        g1   = (s == 4)  ? val : !(pg1 && qg1);
        pg2  = (s == 5)  ? val : p;
        g1g2 = (s == 6)  ? val : g1;
        g1g3 = (s == 7)  ? val : g1;
        qg3  = (s == 8)  ? val : q;
        g2   = (s == 9)  ? val : !(pg2 && g1g2);
        g3   = (s == 10) ? val : !(qg3 && g1g3);
        y    = (s == 11) ? val : !(g2 && g3);
        return y;
    endfunction

    task automatic load_set(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vec_we = 1'b1;
            vec_addr = AW'(i);
            vec_wdata = vset[i];
        end
        @(negedge clk);
        vec_we = 1'b0;
    endtask

    task automatic run_set(input int n, input bit poke, input string name);
        int exp_lat, exp_cnt, lat;
        bit exp_flag [NF];
        bit got;
        exp_lat = 1 + n;
        exp_cnt = 0;
        for (int f = 0; f < NF; f++) begin
            int k;
            k = 0;
            exp_flag[f] = 1'b0;
            for (int i = 0; i < n; i++) begin
                if (k == 0 && model(vset[i], f, 1'b1) != model(vset[i], f, 1'b0)) k = i + 1;
            end
            if (n > 0) begin
                exp_lat += ((k == 0) ? n : k) + 1;
            end
            if (k != 0) begin
                exp_flag[f] = 1'b1;
                exp_cnt++;
            end
        end
        if (n == 0) exp_lat = 1;
        @(negedge clk);
        vec_count = CW'(n);
        start = 1'b1;
        lat = 0;
        got = 1'b0;
        while (!got && lat < 5000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (poke && lat == 2) ? 1'b1 : 1'b0;
            if (lat == 1 && n > 0) check(busy == 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
            if (done) got = 1'b1;
        end
        // R6 R3 R9 latency (a restart by the poke would stretch it, R2)
        check(lat == exp_lat, poke ? "R2" : (n == 0 ? "R9" : "R6"), {name, " cycles to done"}, lat, exp_lat);
        check(busy == 1'b0, "R8", {name, " busy with done"}, int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R8", {name, " done width"}, int'(done), 0);
        check(int'(det_count) == exp_cnt, n == 0 ? "R9" : "R7", {name, " det_count"}, int'(det_count), exp_cnt);
        check($countones(det_flags) == int'(det_count), "R7", {name, " count vs flags"},
              $countones(det_flags), int'(det_count));
        for (int f = 0; f < NF; f++) begin
            // R4 R5 R10 per-fault detection
            check(det_flags[f] == exp_flag[f], "R5", $sformatf("%s R4 fault %0d", name, f),
                  int'(det_flags[f]), int'(exp_flag[f]));
        end
        repeat (5) @(negedge clk);
        check(int'(det_count) == exp_cnt, "R7", {name, " count held"}, int'(det_count), exp_cnt);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(done == 1'b0, "R1", "done", int'(done), 0);
        check(det_count == '0, "R1", "det_count", int'(det_count), 0);
        check(det_flags == '0, "R1", "det_flags", int'(det_flags), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // every single-vector set
        for (int a = 0; a < 4; a++) begin
            vset[0] = 2'(a);
            load_set(1);
            run_set(1, 1'b0, $sformatf("single %0d", a));
        end
        // every ordered pair
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                vset[0] = 2'(a);
                vset[1] = 2'(b);
                load_set(2);
                run_set(2, 1'b0, $sformatf("pair %0d%0d", a, b));
            end
        end
        // full truth table in two orders
        for (int i = 0; i < 4; i++) vset[i] = 2'(i);
        load_set(4);
        run_set(4, 1'b0, "all4 up");
        for (int i = 0; i < 4; i++) vset[i] = 2'(3 - i);
        load_set(4);
        run_set(4, 1'b1, "all4 down poke");
        // full depth, repeated vectors
        for (int i = 0; i < VD; i++) vset[i] = 2'((i * 3 + i / 4) % 4);
        load_set(VD);
        run_set(VD, 1'b0, "depth");
        for (int i = 0; i < VD; i++) vset[i] = 2'b11;
        load_set(VD);
        run_set(VD, 1'b0, "depth same");
        // empty set
        run_set(0, 1'b0, "empty");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule